// File: doc/BRIEF.md
# Watchdog Timer with One-Time Action Lock

This block guards a small processor against runaway code and deadlock. A binary count advances on every clock while the timer runs; software must restart it by writing a clear key to a command register before the count reaches the period limit. If software fails to do so, the block raises one of two alarms. The first is a single-cycle reset request for the system reset controller. The second is a sticky non-maskable interrupt request that stays high until it is acknowledged.

Which alarm is raised is fixed by the first write to the control register after reset. Later writes cannot change that choice. The period is one of four divider taps, and a clock-mode input selects a second set of four taps for use with a slow clock. Stopping the timer takes two steps: software clears the enable bit, then writes a stop key. With the interrupt action chosen, the block also works as a periodic interval timer.

Top module: `wdt_guard`

## Requirements
- R1: Reset (synchronous, active low) leaves the timer running with period select 0, the reset-request action, the count at 0, both alarms low, and `ctrl_rd` reading 8'h80.
- R2: Starting from a count of 0, an overflow occurs after exactly 2^E clocks of running. E is the tap exponent chosen by the period select: 23, 21, 19 or 17 for selects 0 to 3 when `slow_mode` is 0, and 15, 13, 11 or 9 when `slow_mode` is 1. After an overflow the count restarts from 0.
- R3: `ctrl_rd` returns bit 7 as the last written enable bit, bits 2:1 as the period select and bit 0 as the locked action (0 = reset request, 1 = interrupt). All other bits read 0. A control write is `wr_en`=1 with `wr_cmd`=0.
- R4: A command write (`wr_en`=1, `wr_cmd`=1) of 8'h4E restarts the count at 0 on that edge.
- R5: In reset-request action, an overflow drives `rst_req` high for exactly one clock, in the cycle after the count reaches its limit.
- R6: In interrupt action, an overflow sets `nmi_req`, and it stays set until `irq_ack` is high at a clock edge. If an overflow and `irq_ack` fall on the same edge, the overflow wins.
- R7: Only the first control write after reset sets the action bit. Bit 0 of later control writes is ignored until the next reset.
- R8: The timer stops (`running` falls) only when the stop key 8'hB1 is written while the last written enable bit is 0. A stop key written while that bit is 1 has no effect. A control write with bit 7 set starts the timer again. While stopped, the count stays at 0 and no alarm is raised.
- R9: A command write of any value other than 8'h4E or 8'hB1 has no effect.
- R10: The limit is compared with "count at or above limit", so switching to a shorter period while the count already exceeds the new limit causes an overflow on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slow_mode | input | 1 | Selects the slow-clock tap set |
| wr_en | input | 1 | Register write strobe |
| wr_cmd | input | 1 | 0 = control register, 1 = command register |
| wr_data | input | 8 | Write data |
| irq_ack | input | 1 | Acknowledge for the interrupt request |
| ctrl_rd | output | 8 | Control register readback |
| running | output | 1 | High while the timer counts |
| rst_req | output | 1 | One-cycle reset request |
| nmi_req | output | 1 | Sticky non-maskable interrupt request |

## Verification
A count that is off by even one step shows up as an alarm edge one clock early or late. The bench compares every clock against a behavioural model, so such a fault appears at the first overflow after it occurs, and at the latest one full period later. A lost action lock or a wrong enable state shows up at once on `ctrl_rd` or `running`, and then as the wrong alarm at the next overflow. A misread key has no visible effect until the period runs out unexpectedly, or fails to run out.

// File: rtl/wdt_pkg.sv
// Shared constants for the watchdog: register width, key values and
// control field positions. Assumes an 8-bit register write bus.
package wdt_pkg;
    localparam int REG_W = 8;
    localparam logic [REG_W-1:0] KEY_CLEAR = 8'h4E;
    localparam logic [REG_W-1:0] KEY_STOP  = 8'hB1;
    localparam int BIT_EN  = 7;
    localparam int BIT_SEL = 1;  // two bits: [2:1]
    localparam int BIT_ACT = 0;
    localparam int NTAPS   = 4;
    localparam int SEL_W   = $clog2(NTAPS);
endpackage

// File: rtl/wdt_regs.sv
// Register file of the watchdog: control register with a one-time action
// lock, and a command decoder for the clear and stop keys.
// Assumes writes are single-cycle strobes synchronous to clk.
module wdt_regs
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_cmd,
    input  logic [REG_W-1:0] wr_data,
    output logic             run,
    output logic [SEL_W-1:0] per_sel,
    output logic             act_nmi,
    output logic             clr_hit,
    output logic [REG_W-1:0] ctrl_rd
);
    logic en_req;
    logic act_lock;
    logic ctrl_wr;
    logic stop_hit;

    assign ctrl_wr  = wr_en && !wr_cmd;
    assign clr_hit  = wr_en && wr_cmd && (wr_data == KEY_CLEAR);
    assign stop_hit = wr_en && wr_cmd && (wr_data == KEY_STOP);

    // Control fields: enable request and period select follow every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_req  <= 1'b1;
            per_sel <= '0;
        end else if (ctrl_wr) begin
            en_req  <= wr_data[BIT_EN];
            per_sel <= wr_data[BIT_SEL +: SEL_W];
        end
    end

    // Action bit: taken from the first control write only, then frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_nmi  <= 1'b0;
            act_lock <= 1'b0;
        end else if (ctrl_wr && !act_lock) begin
            act_nmi  <= wr_data[BIT_ACT];
            act_lock <= 1'b1;
        end
    end

    // Run state: set by an enabling write, cleared only by stop key after enable cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b1;
        end else if (ctrl_wr && wr_data[BIT_EN]) begin
            run <= 1'b1;
        end else if (stop_hit && !en_req) begin
            run <= 1'b0;
        end
    end

    // Readback image of the control register.
    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[BIT_EN] = en_req;
        ctrl_rd[BIT_SEL +: SEL_W] = per_sel;
        ctrl_rd[BIT_ACT] = act_nmi;
    end

    AST_ACT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        act_lock |=> $stable(act_nmi)); // R7
    AST_STOP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> $past(stop_hit && !en_req)); // R8
endmodule

// File: rtl/wdt_prescaler.sv
// Binary prescaler with a four-way tap select per clock mode.
// Overflow is flagged when the count is at or above the chosen limit;
// the count then restarts. Assumes every exponent is at least 1.
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int NRM_EXP [NTAPS] = '{23, 21, 19, 17},
    parameter int LOW_EXP [NTAPS] = '{15, 13, 11, 9}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             slow_mode,
    input  logic [SEL_W-1:0] per_sel,
    output logic             ovf
);
    function automatic int widest();
        int m = 1;
        for (int i = 0; i < NTAPS; i++) begin
            if (NRM_EXP[i] > m) m = NRM_EXP[i];
            if (LOW_EXP[i] > m) m = LOW_EXP[i];
        end
        return m;
    endfunction

    localparam int CNT_W = widest();

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    int               tap_e;

    // Limit for the selected tap: 2^E - 1.
    always_comb begin
        tap_e = slow_mode ? LOW_EXP[per_sel] : NRM_EXP[per_sel];
        limit = (CNT_W'(1) << tap_e) - CNT_W'(1);
    end

    assign ovf = run && (cnt >= limit);

    // Count advance, restart on clear, overflow or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || clr || ovf) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0)); // R8
endmodule

// File: rtl/wdt_action.sv
// Alarm stage: turns an overflow into a one-cycle reset request or a sticky
// interrupt request, chosen by the locked action bit.
module wdt_action (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic act_nmi,
    input  logic irq_ack,
    output logic rst_req,
    output logic nmi_req
);
    // Reset request pulse on overflow in reset action.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= ovf && !act_nmi;
    end

    // Sticky interrupt flag; a new overflow beats an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)              nmi_req <= 1'b0;
        else if (ovf && act_nmi) nmi_req <= 1'b1;
        else if (irq_ack)        nmi_req <= 1'b0;
    end

    AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R5
    AST_NMI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !irq_ack) |=> nmi_req); // R6
endmodule

// File: rtl/wdt_guard.sv
// Watchdog top: registers, prescaler and alarm stage.
// Assumes a single clock; slow_mode only picks the tap set.
module wdt_guard
    import wdt_pkg::*;
#(
    parameter int NRM_EXP [NTAPS] = '{23, 21, 19, 17},
    parameter int LOW_EXP [NTAPS] = '{15, 13, 11, 9}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_mode,
    input  logic             wr_en,
    input  logic             wr_cmd,
    input  logic [REG_W-1:0] wr_data,
    input  logic             irq_ack,
    output logic [REG_W-1:0] ctrl_rd,
    output logic             running,
    output logic             rst_req,
    output logic             nmi_req
);
    logic             run;
    logic [SEL_W-1:0] per_sel;
    logic             act_nmi;
    logic             clr_hit;
    logic             ovf;

    wdt_regs i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd),
        .wr_data(wr_data), .run(run), .per_sel(per_sel),
        .act_nmi(act_nmi), .clr_hit(clr_hit), .ctrl_rd(ctrl_rd)
    );

    wdt_prescaler #(.NRM_EXP(NRM_EXP), .LOW_EXP(LOW_EXP)) i_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(clr_hit),
        .slow_mode(slow_mode), .per_sel(per_sel), .ovf(ovf)
    );

    wdt_action i_act (
        .clk(clk), .rst_n(rst_n), .ovf(ovf), .act_nmi(act_nmi),
        .irq_ack(irq_ack), .rst_req(rst_req), .nmi_req(nmi_req)
    );

    assign running = run;

    AST_QUIET_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> !rst_req && !$rose(nmi_req)); // R8
endmodule

// File: tb/test_wdt_guard.sv
// Bench: behavioural reference model compared with the ports on every clock,
// plus directed checks. Reduced tap exponents keep the run short.
module test_wdt_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_mode = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_cmd = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       irq_ack = 1'b0;
    logic [7:0] ctrl_rd;
    logic       running, rst_req, nmi_req;

    int nrm_e [4] = '{9, 7, 5, 3};
    int low_e [4] = '{8, 6, 4, 2};

    wdt_guard #(.NRM_EXP('{9, 7, 5, 3}), .LOW_EXP('{8, 6, 4, 2})) i_wdt_guard (
        .clk(clk), .rst_n(rst_n), .slow_mode(slow_mode), .wr_en(wr_en),
        .wr_cmd(wr_cmd), .wr_data(wr_data), .irq_ack(irq_ack),
        .ctrl_rd(ctrl_rd), .running(running), .rst_req(rst_req),
        .nmi_req(nmi_req)
    );

    always #10 clk = ~clk;

    int vectors = 0;
    int errors = 0;
    int pulses = 0;
    int cycles = 0;
    bit live = 0;
    bit done = 0;

    // model state
    bit m_en = 1, m_req = 1, m_act = 0, m_lock = 0, m_rst = 0, m_nmi = 0;
    int m_sel = 0;
    longint m_cnt = 0;

    task automatic chk(string tag, longint got, longint exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at cycle %0d", tag, got, exp, cycles);
        end
    endtask

    // Reference model, advanced on each rising edge from the stable inputs.
    always @(posedge clk) begin
        longint lim;
        bit ovf;
        live <= 1;
        cycles++;
        if (!rst_n) begin
            m_en = 1; m_req = 1; m_sel = 0; m_act = 0; m_lock = 0;
            m_cnt = 0; m_rst = 0; m_nmi = 0;
        end else begin
            lim = (longint'(1) << (slow_mode ? low_e[m_sel] : nrm_e[m_sel])) - 1;
            ovf = m_en && (m_cnt >= lim);
            if (!m_en || ovf || (wr_en && wr_cmd && wr_data == 8'h4E)) m_cnt = 0;
            else m_cnt++;
            m_rst = ovf && !m_act;
            if (ovf && m_act) m_nmi = 1;
            else if (irq_ack) m_nmi = 0;
            if (wr_en && !wr_cmd) begin
                m_req = wr_data[7];
                m_sel = int'(wr_data[2:1]);
                if (!m_lock) begin m_act = wr_data[0]; m_lock = 1; end
                if (wr_data[7]) m_en = 1;
            end else if (wr_en && wr_cmd && wr_data == 8'hB1 && !m_req) begin
                m_en = 0;
            end
        end
    end

    // Port comparison against the model on every falling edge.
    always @(negedge clk) begin
        if (live && !done) begin
            chk("R5 rst_req", rst_req, m_rst);
            chk("R6 nmi_req", nmi_req, m_nmi);
            chk("R8 running", running, m_en);
            chk("R3 ctrl_rd", ctrl_rd, {m_req, 4'b0, 2'(m_sel), m_act});
            if (rst_req) pulses++;
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(bit cmd, logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_cmd = cmd; wr_data = d;
        @(negedge clk);
        wr_en = 0; wr_cmd = 0; wr_data = 8'h00;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        int p0;
        idle(3);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 ctrl", ctrl_rd, 8'h80);
        chk("R1 running", running, 1);
        chk("R1 alarms", {rst_req, nmi_req}, 0);
        // R2: first overflow after 2^9 clocks with default select
        idle(520);
        chk("R2 one pulse at 2^9", pulses, 1);
        // lock reset action, shortest period (8)
        wr(0, 8'h86);
        idle(30);
        // R7: attempt to switch to interrupt action
        wr(0, 8'h87);
        chk("R7 act stays", ctrl_rd[0], 0);
        idle(20);
        // R4: clears every 5 cycles keep alarms away
        p0 = pulses;
        for (int i = 0; i < 8; i++) begin wr(1, 8'h4E); idle(3); end
        chk("R4 no pulse", pulses - p0, 0);
        // R9: junk command values have no effect
        wr(1, 8'h00); wr(1, 8'h4F); wr(1, 8'hB0);
        idle(20);
        chk("R9 still running", running, 1);
        // R8: stop key with enable set is ignored
        wr(1, 8'hB1);
        chk("R8 stop ignored", running, 1);
        wr(0, 8'h06);
        idle(12);
        chk("R8 clear bit alone", running, 1);
        wr(1, 8'hB1);
        p0 = pulses;
        idle(40);
        chk("R8 stopped", running, 0);
        chk("R8 no alarm", pulses - p0, 0);
        // slow tap set, select 3 (period 4)
        slow_mode = 1;
        wr(0, 8'h86);
        idle(25);
        slow_mode = 0;
        // R10: long period, then shrink with count above new limit
        wr(0, 8'h80);
        idle(100);
        wr(0, 8'h86);
        idle(10);
        // interrupt action after a fresh reset
        @(negedge clk); rst_n = 0;
        idle(2); rst_n = 1;
        wr(0, 8'h85);
        idle(40);
        chk("R6 nmi held", nmi_req, 1);
        idle(30);
        @(negedge clk); irq_ack = 1;
        @(negedge clk); irq_ack = 0;
        chk("R6 acked", nmi_req, 0);
        // ack held across an overflow edge: overflow wins
        wr(0, 8'h87);
        @(negedge clk); irq_ack = 1;
        idle(20);
        irq_ack = 0;
        idle(10);
        finish_run();
    end

    // Watchdog for a hung run.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule